// File: doc/BRIEF.md
# SPI Slave Buffered Shift Path

This block is the serial datapath of an SPI slave. The serial shifter is decoupled from the parallel side by a one-word transmit holding register and a receive capture register. Because of this, frames can follow each other with no gap while select stays low. The serial inputs `sck`, `ss_n` and `mosi` are brought into the system clock domain through two-flop synchronisers. SCK edges are then found there, so SCK must run well below the system clock.

Clocking is fixed to SPI mode 0. The master samples on rising SCK and the slave changes MISO after falling SCK. Bits travel most significant first. The frame length is programmable. A complete frame produces one `rx_valid` strobe toward a downstream FIFO. A frame that select cuts short produces only a `frame_lost` pulse. Transmit words are offered on `tx_data`/`tx_valid` and accepted with a one-cycle `tx_take`.

Top module: `spi_slave_bufpath`

## Requirements
- R1: A frame is N = max(F,3)+1 bits long, where F is the 4-bit `frame_size` field, so F = 0, 1, 2 and 3 all give 4-bit frames and F = 15 gives 16 bits.
- R2: On the Nth rising SCK edge of a frame, `rx_data` takes the N received bits for one `rx_valid` pulse. The first bit received lands in bit N-1 and bits above N-1 read zero. `rx_data` changes at no other time.
- R3: MISO presents bits N-1 down to 0 of the word being sent. The first bit is present before the first rising edge, and each later bit appears after the falling edge that follows a rising edge.
- R4: While select is negated and the shifter holds no word, a valid `tx_data` word is loaded into the shifter immediately, with a one-cycle `tx_take`.
- R5: While select is asserted, a pending word is accepted on the second SCK edge of a frame (its first falling edge), at most once per frame. It is sent in the next frame with no gap.
- R6: If no word is ready when a frame starts, either at select assertion or at the end of the previous frame in a stream, the frame sends all zeros and `tx_underflow` pulses for one cycle.
- R7: If select negates before the Nth rising edge, `frame_lost` pulses, `rx_valid` does not fire, `rx_data` keeps its value, the partly sent word is dropped and the next frame starts counting from bit one.
- R8: If select negates after a complete frame, `frame_lost` stays low.
- R9: `rx_valid` rises on the third system clock edge after the SCK rising edge that completes the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from master, idle low |
| ss_n | input | 1 | Active-low slave select |
| mosi | input | 1 | Serial data from master |
| miso | output | 1 | Serial data to master |
| frame_size | input | 4 | Frame length field F, N = max(F,3)+1 |
| tx_data | input | 16 | Word to transmit, right-aligned |
| tx_valid | input | 1 | `tx_data` is offered |
| tx_take | output | 1 | One-cycle accept of `tx_data` |
| tx_underflow | output | 1 | One-cycle pulse: frame started without a word |
| rx_data | output | 16 | Received word, right-aligned |
| rx_valid | output | 1 | One-cycle strobe: `rx_data` is new |
| frame_lost | output | 1 | One-cycle pulse: frame aborted by select |

## Verification
Every result of this block lags the SCK or select edge that causes it by three system clock edges: two synchroniser stages, then the registered update. MISO follows the same lag after a falling SCK edge. The bench therefore holds each SCK phase for eight clocks and reads MISO just before it raises SCK. For the capture latency, it samples `rx_valid` on the falling clock edge after the second and after the third rising clock edge following the final SCK rise. Pulse outputs are counted by a monitor and compared as deltas once each frame has settled.

// File: rtl/spi_slave_bufpath.sv
module spi_slave_bufpath #(
  parameter int FSW = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sck,
  input  logic                ss_n,
  input  logic                mosi,
  output logic                miso,
  input  logic [FSW-1:0]      frame_size,
  input  logic [(1<<FSW)-1:0] tx_data,
  input  logic                tx_valid,
  output logic                tx_take,
  output logic                tx_underflow,
  output logic [(1<<FSW)-1:0] rx_data,
  output logic                rx_valid,
  output logic                frame_lost
);
  localparam int DW = 1 << FSW;

  logic [2:0]     sck_q, ss_q;
  logic [1:0]     mosi_q;
  logic [FSW-1:0] cnt, last_idx;
  logic [DW-1:0]  tx_sh, tx_buf, rx_sh, rx_word, rx_mask;
  logic           tx_loaded, buf_full;

  wire sel       = ~ss_q[1];
  wire sel_on    = ~ss_q[1] & ss_q[2];
  wire sel_off   = ss_q[1] & ~ss_q[2];
  wire rise      = sck_q[1] & ~sck_q[2];
  wire fall      = ~sck_q[1] & sck_q[2];
  wire last_rise = sel & rise & (cnt == last_idx);
  wire grab      = sel & fall & (cnt == FSW'(1)) & tx_valid & ~buf_full;
  wire idle_load = ~sel & ~sel_off & ~tx_loaded & (buf_full | tx_valid);

  assign last_idx = (frame_size < FSW'(3)) ? FSW'(3) : frame_size;
  assign rx_mask  = ~(({DW{1'b1}} << last_idx) << 1);
  assign rx_word  = {rx_sh[DW-2:0], mosi_q[1]} & rx_mask;
  assign miso     = tx_sh[last_idx];
  assign tx_take  = grab | (idle_load & ~buf_full);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= '0;
      ss_q   <= '1;
      mosi_q <= '0;
    end else begin
      sck_q  <= {sck_q[1:0], sck};
      ss_q   <= {ss_q[1:0], ss_n};
      mosi_q <= {mosi_q[0], mosi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt          <= '0;
      tx_sh        <= '0;
      tx_buf       <= '0;
      rx_sh        <= '0;
      rx_data      <= '0;
      tx_loaded    <= 1'b0;
      buf_full     <= 1'b0;
      rx_valid     <= 1'b0;
      frame_lost   <= 1'b0;
      tx_underflow <= 1'b0;
    end else begin
      rx_valid     <= 1'b0;
      frame_lost   <= 1'b0;
      tx_underflow <= 1'b0;
      if (sel_off) begin
        cnt <= '0;
        if (cnt != '0) begin
          frame_lost <= 1'b1;
          tx_loaded  <= 1'b0;
          tx_sh      <= '0;
        end
      end else if (sel) begin
        if (sel_on && !tx_loaded) tx_underflow <= 1'b1;
        if (rise) begin
          rx_sh <= {rx_sh[DW-2:0], mosi_q[1]};
          cnt   <= cnt + 1'b1;
        end
        if (last_rise) begin
          cnt      <= '0;
          rx_data  <= rx_word;
          rx_valid <= 1'b1;
          buf_full <= 1'b0;
          if (buf_full) begin
            tx_sh     <= tx_buf;
            tx_loaded <= 1'b1;
          end else begin
            tx_sh        <= '0;
            tx_loaded    <= 1'b0;
            tx_underflow <= 1'b1;
          end
        end
        if (fall && cnt != '0) tx_sh <= tx_sh << 1;
        if (grab) begin
          tx_buf   <= tx_data;
          buf_full <= 1'b1;
        end
      end else if (idle_load) begin
        tx_sh     <= buf_full ? tx_buf : tx_data;
        tx_loaded <= 1'b1;
        buf_full  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spi_slave_bufpath_chk.sv
module spi_slave_bufpath_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_valid,
  input logic          tx_take,
  input logic          tx_underflow,
  input logic [DW-1:0] rx_data,
  input logic          rx_valid,
  input logic          frame_lost
);
  a_r2_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  a_r2_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_data) |-> rx_valid);
  a_r7_lost_no_rx: assert property (@(posedge clk) disable iff (!rst_n)
    frame_lost |-> !rx_valid);
  a_r6_uflow_single: assert property (@(posedge clk) disable iff (!rst_n)
    tx_underflow |=> !tx_underflow);
  a_r4_take_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    tx_take |-> tx_valid);
  a_r5_take_single: assert property (@(posedge clk) disable iff (!rst_n)
    tx_take |=> !tx_take);
endmodule

bind spi_slave_bufpath spi_slave_bufpath_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_take(tx_take),
  .tx_underflow(tx_underflow), .rx_data(rx_data), .rx_valid(rx_valid),
  .frame_lost(frame_lost)
);

// File: tb/test_spi_slave_bufpath.sv
module test_spi_slave_bufpath;
  localparam int HALF = 8;
  localparam int NV = 6;
  localparam logic [35:0] VEC [NV] = '{
    {4'd7,  16'h00A5, 16'h005C},
    {4'd15, 16'hBEEF, 16'h1234},
    {4'd3,  16'h000B, 16'h0006},
    {4'd0,  16'hFFF9, 16'hFFF3},
    {4'd9,  16'h0301, 16'h02AA},
    {4'd12, 16'h1C3D, 16'h0F0F}
  };

  logic clk = 0, rst_n = 0, sck = 0, ss_n = 1, mosi = 0;
  logic [3:0] frame_size = 4'd7;
  logic [15:0] tx_data = '0;
  logic miso, tx_take, tx_underflow, rx_valid, frame_lost;
  logic [15:0] rx_data;
  int offers = 0, takes = 0, n_rx = 0, n_uf = 0, n_lost = 0;
  logic [15:0] last_rx = '0;
  int tests = 0, fails = 0;
  bit done = 0;
  wire tx_valid = (offers != takes);

  always #5 clk = ~clk;

  spi_slave_bufpath i_spi_slave_bufpath (
    .clk(clk), .rst_n(rst_n), .sck(sck), .ss_n(ss_n), .mosi(mosi), .miso(miso),
    .frame_size(frame_size), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_take(tx_take), .tx_underflow(tx_underflow), .rx_data(rx_data),
    .rx_valid(rx_valid), .frame_lost(frame_lost)
  );

  always @(posedge clk) if (rst_n) begin
    if (tx_take) takes++;
    if (tx_underflow) n_uf++;
    if (frame_lost) n_lost++;
    if (rx_valid) begin n_rx++; last_rx = rx_data; end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] msk(input logic [3:0] f);
    int n = (f < 3) ? 4 : f + 1;
    return 16'((32'h1 << n) - 1);
  endfunction

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic offer(input logic [15:0] w);
    @(negedge clk);
    tx_data = w;
    offers++;
  endtask

  task automatic sbit(input logic mb, output logic sb);
    mosi = mb;
    waitc(HALF);
    sb = miso;
    sck = 1;
    waitc(HALF);
    sck = 0;
  endtask

  task automatic frame(input int n, input logic [15:0] mo, output logic [15:0] so);
    logic b;
    so = '0;
    for (int i = n - 1; i >= 0; i--) begin
      sbit(mo[i], b);
      so[i] = b;
    end
  endtask

  task automatic sel(input logic v);
    @(negedge clk);
    ss_n = v;
    waitc(HALF);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] so;
    int r0, u0, l0, t0, n;
    waitc(3);
    chk(rx_valid === 0 && frame_lost === 0 && tx_take === 0 && tx_underflow === 0,
        "R2 reset outputs", {rx_valid, frame_lost, tx_take, tx_underflow}, 0);
    chk(rx_data === 0 && miso === 0, "R3 reset data", {rx_data, 15'd0, miso}, 0);
    rst_n = 1;
    waitc(3);

    for (int v = 0; v < NV; v++) begin
      frame_size = VEC[v][35:32];
      n = (frame_size < 3) ? 4 : frame_size + 1;
      r0 = n_rx; l0 = n_lost; u0 = n_uf;
      offer(VEC[v][31:16]);
      waitc(6);
      chk(takes == offers, "R4 idle take", takes, offers);
      sel(0);
      frame(n, VEC[v][15:0], so);
      waitc(6);
      chk(n_rx == r0 + 1 && last_rx == (VEC[v][15:0] & msk(frame_size)),
          "R1 R2 rx word", last_rx, VEC[v][15:0] & msk(frame_size));
      chk(so == (VEC[v][31:16] & msk(frame_size)), "R1 R3 miso word", so,
          VEC[v][31:16] & msk(frame_size));
      sel(1);
      waitc(4);
      chk(n_lost == l0, "R8 no loss", n_lost, l0);
      chk(n_uf == u0 + 1, "R6 end-of-frame underflow", n_uf, u0 + 1);
    end

    // R5 streaming and R6 underflow inside a stream
    frame_size = 4'd7;
    offer(16'h00C3);
    waitc(6);
    offer(16'h005A);
    waitc(6);
    chk(takes == offers - 1, "R5 held while shifter full", takes, offers - 1);
    u0 = n_uf; r0 = n_rx; t0 = takes;
    sel(0);
    frame(8, 16'h0011, so);
    chk(so == 16'h00C3 && takes == t0 + 1, "R5 first stream frame", {so, 8'd0, 8'(takes - t0)}, {16'h00C3, 16'd1});
    frame(8, 16'h0022, so);
    chk(so == 16'h005A, "R5 second stream frame", so, 16'h005A);
    frame(8, 16'h0033, so);
    chk(so == 16'h0000, "R6 zeros sent", so, 0);
    waitc(6);
    chk(n_rx == r0 + 3 && last_rx == 16'h0033, "R2 stream rx", last_rx, 16'h0033);
    chk(n_uf == u0 + 2, "R6 stream underflow", n_uf, u0 + 2);
    sel(1);

    // R7 lost frame
    offer(16'h00F0);
    waitc(6);
    r0 = n_rx; l0 = n_lost;
    sel(0);
    for (int i = 0; i < 3; i++) begin logic b; sbit(1'b1, b); end
    sel(1);
    waitc(4);
    chk(n_lost == l0 + 1, "R7 loss pulse", n_lost, l0 + 1);
    chk(n_rx == r0 && last_rx == 16'h0033 && rx_data == 16'h0033, "R7 rx kept", rx_data, 16'h0033);

    // R6 at select assertion, R7 count restart
    u0 = n_uf;
    sel(0);
    frame(8, 16'h00E7, so);
    waitc(6);
    chk(so == 16'h0000 && n_uf == u0 + 2, "R6 select underflow", {so, 16'(n_uf - u0)}, {16'h0, 16'd2});
    chk(n_rx == r0 + 1 && last_rx == 16'h00E7, "R7 restart count", last_rx, 16'h00E7);
    sel(1);

    // R9 latency
    offer(16'h0009);
    waitc(6);
    frame_size = 4'd3;
    sel(0);
    for (int i = 3; i >= 1; i--) begin logic b; sbit(1'b0, b); end
    mosi = 1'b1;
    waitc(HALF);
    sck = 1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(rx_valid === 0, "R9 not early", rx_valid, 0);
    @(posedge clk);
    @(negedge clk);
    chk(rx_valid === 1 && rx_data == 16'h0001, "R9 on third edge", {rx_valid, rx_data}, {1'b1, 16'h0001});
    waitc(HALF);
    sck = 0;
    sel(1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule